// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral on a plain 32-bit register bus. A 16-bit counter climbs by one on every prescaled tick while the timer runs. When it rolls over from 0xFFFF to 0, the block drives a reset request for a fixed number of clock cycles. It also sets a sticky overflow flag, clears the run bit and parks the counter at zero. Software keeps the system alive by reloading the counter before it rolls over. A load value of V gives a timeout of (65536 − V) prescaled ticks.

Every write must carry a key in its upper bits, or the block drops it. The counter register and the two control registers use different keys, so a stray store is very unlikely to disturb the timer. The overflow flag survives the reset that the watchdog itself requests. Boot code can read it to find the cause of the last reset. A write-pending flag tells software when an accepted write has been applied.

The prescaler counts cycles of the `tick_i` clock enable. It divides them by one of eight non-uniform ratios, chosen by a 3-bit field.

Top module: `guard_timer`

## Requirements
- R1: A write to offset 0x0 is taken only when wdata[31:16] = 0x5A5A. The counter then loads wdata[15:0]. Any other write to offset 0x0 leaves the counter unchanged. Without a write, the counter changes only by +1, which includes the wrap from 0xFFFF to 0.
- R2: A write to offset 0x4 (control A) or offset 0x8 (control B) is taken only when wdata[31:8] = 0xA5A5A5. Any other write to those offsets has no effect.
- R3: Control A reads as {24'b0, run[7], 0[6], busy[5], ovf[4], 0[3], sel[2:0]}. A keyed write sets run from bit 7 and sel from bits [2:0]. Bit 5 is read-only. After power-on reset, control A reads 0.
- R4: While run = 1, the counter steps once per N cycles in which `tick_i` is high. N is 1, 4, 16, 32, 64, 128, 1024 or 4096 for sel = 0 to 7. Cycles with `tick_i` low are not counted. After enabling with load value V, the counter overflows after (65536 − V)·N ticks.
- R5: Loading 0xFFFF while running at sel = 0 with `tick_i` held high gives an overflow on the very next cycle.
- R6: On overflow, `wdt_rst_o` is high for exactly 16 cycles. At the same time ovf becomes 1, run becomes 0, and the counter stays at 0 until it is re-enabled.
- R7: ovf is cleared only by `rst_ni` or by a keyed control-A write with bit 4 = 0. A keyed write with bit 4 = 1 leaves ovf set.
- R8: Any accepted write makes `wr_busy_o` high for exactly the 2 following cycles. A write that is not accepted does not raise it.
- R9: Control B is an 8-bit read/write register with no effect on counting. Offset 0x0 reads as {16'b0, counter}. Every other offset reads 0.
- R10: While run = 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Timer clock enable that feeds the prescaler |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data, key in the upper bits |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| wdt_rst_o | output | 1 | Reset request pulse |
| wr_busy_o | output | 1 | Write-pending status |

## Verification
The bench sweeps all eight prescaler settings from a load of 0xFFFC and counts cycles to the reset request against 4·N. A wrong divider entry, an off-by-one terminal count, or a prescaler that keeps its phase across a disable would each shift that count. The pulse width, the sticky flag and the parked counter are checked after every overflow. A design that reloaded on overflow or cleared the flag would give a second reset or lose the boot cause. Writes with wrong keys, and ovf writes with bit 4 set, are checked to leave state alone. Loading 0xFFFF must give an overflow one cycle later, and a gated `tick_i` must stall counting.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_CNT = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTA = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTB = 4'h8;
  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;
  localparam int BIT_RUN  = 7;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OVF  = 4;

  // terminal count of the prescaler (ratio - 1)
  function automatic logic [11:0] psc_tc(input logic [2:0] sel);
    case (sel)
      3'd0:    return 12'd0;
      3'd1:    return 12'd3;
      3'd2:    return 12'd15;
      3'd3:    return 12'd31;
      3'd4:    return 12'd63;
      3'd5:    return 12'd127;
      3'd6:    return 12'd1023;
      default: return 12'd4095;
    endcase
  endfunction
endpackage

// File: rtl/guard_timer_psc.sv
module guard_timer_psc #(
  parameter int PSC_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [2:0] sel_i,
  output logic       strobe_o
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] tc;
  logic             at_tc;

  assign tc       = PSC_W'(guard_timer_pkg::psc_tc(sel_i));
  assign at_tc    = (div_q >= tc);
  assign strobe_o = run_i & tick_i & at_tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!run_i)   div_q <= '0;
    else if (tick_i)   div_q <= at_tc ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/guard_timer_cnt.sv
module guard_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  assign wrap_o = step_i & ~load_i & (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= load_val_i;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/guard_timer_pulse.sv
module guard_timer_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int W = $clog2(LEN + 1);
  logic [W-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (fire_i)  left_q <= W'(LEN);
    else if (pulse_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 12,
  parameter int PULSE_LEN = 16,
  parameter int BUSY_LEN  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  output logic [31:0] rdata_o,
  output logic        wdt_rst_o,
  output logic        wr_busy_o
);
  import guard_timer_pkg::*;

  localparam int BUSY_W = $clog2(BUSY_LEN + 1);

  logic             en_q, ovf_q;
  logic [2:0]       sel_q;
  logic [7:0]       ctb_q;
  logic [BUSY_W-1:0] busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_cnt, wr_cta, wr_ctb, strobe, wrap;

  assign wr_cnt = we_i && (addr_i == OFS_CNT) && (wdata_i[31:16] == KEY_CNT);
  assign wr_cta = we_i && (addr_i == OFS_CTA) && (wdata_i[31:8] == KEY_CTL);
  assign wr_ctb = we_i && (addr_i == OFS_CTB) && (wdata_i[31:8] == KEY_CTL);

  guard_timer_psc #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en_q),
    .tick_i  (tick_i),
    .sel_i   (sel_q),
    .strobe_o(strobe)
  );

  guard_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_cnt),
    .load_val_i(wdata_i[CNT_W-1:0]),
    .step_i    (strobe),
    .cnt_o     (cnt_q),
    .wrap_o    (wrap)
  );

  guard_timer_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wrap),
    .pulse_o(wdt_rst_o)
  );

  // overflow overrides a same-cycle control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      sel_q <= '0;
      ctb_q <= '0;
    end else begin
      if (wr_cta) begin
        en_q  <= wdata_i[BIT_RUN];
        sel_q <= wdata_i[2:0];
        ovf_q <= ovf_q & wdata_i[BIT_OVF];
      end
      if (wr_ctb) ctb_q <= wdata_i[7:0];
      if (wrap) begin
        en_q  <= 1'b0;
        ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         busy_q <= '0;
    else if (wr_cnt || wr_cta || wr_ctb) busy_q <= BUSY_W'(BUSY_LEN);
    else if (busy_q != '0)               busy_q <= busy_q - 1'b1;
  end

  assign wr_busy_o = (busy_q != '0);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CNT: rdata_o[CNT_W-1:0] = cnt_q;
      OFS_CTA: begin
        rdata_o[BIT_RUN]  = en_q;
        rdata_o[BIT_BUSY] = wr_busy_o;
        rdata_o[BIT_OVF]  = ovf_q;
        rdata_o[2:0]      = sel_q;
      end
      OFS_CTB: rdata_o[7:0] = ctb_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             wdt_rst_o,
  input logic             wr_busy_o,
  input logic             en_q,
  input logic             ovf_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam int HW = $clog2(PULSE_LEN + 2) + 1;
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hi_len <= '0;
    else if (!wdt_rst_o)                hi_len <= '0;
    else if (hi_len != '1)              hi_len <= hi_len + 1'b1;
  end

  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (ovf_q && !en_q));

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (hi_len == HW'(PULSE_LEN)));

  // R8
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_o |-> ($past(we_i) || $past(we_i, 2)));

  // R7
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(we_i));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !we_i) |=> $stable(cnt_q));

  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q != $past(cnt_q)) && !$past(we_i)) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .wdt_rst_o(wdt_rst_o),
  .wr_busy_o(wr_busy_o),
  .en_q     (en_q),
  .ovf_q    (ovf_q),
  .cnt_q    (cnt_q)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        wrst, busy;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guard_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata),
    .wdt_rst_o(wrst), .wr_busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  function automatic int ratio(input int s);
    int r [8] = '{1, 4, 16, 32, 64, 128, 1024, 4096};
    return r[s];
  endfunction

  task automatic wait_ovf(output int n);
    n = 0;
    while (!wrst && n < LIMIT) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic pulse_len(output int h);
    h = 0;
    while (wrst && h < 100) begin
      h++; @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, h;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(4'h4, v); chk("R3 reset ctl A", v, 32'h0);
    rd(4'h0, v); chk("R9 reset counter", v, 32'h0);
    rd(4'h8, v); chk("R9 reset ctl B", v, 32'h0);
    chk("R6 reset wdt_rst_o", {31'b0, wrst}, 32'h0);

    // busy window and ctl B
    wr(4'h8, 32'hA5A5A53C);
    chk("R8 busy cycle 1", {31'b0, busy}, 32'h1);
    @(posedge clk); #1 chk("R8 busy cycle 2", {31'b0, busy}, 32'h1);
    @(posedge clk); #1 chk("R8 busy cleared", {31'b0, busy}, 32'h0);
    rd(4'h8, v); chk("R9 ctl B readback", v, 32'h3C);
    wr(4'h8, 32'h12345677);
    chk("R8 rejected write no busy", {31'b0, busy}, 32'h0);
    rd(4'h8, v); chk("R2 bad key ctl B", v, 32'h3C);

    // counter key
    wr(4'h0, 32'h5A5A1234);
    rd(4'h0, v); chk("R1 keyed load", v, 32'h1234);
    wr(4'h0, 32'h5A5B0000);
    rd(4'h0, v); chk("R1 bad key load", v, 32'h1234);
    rd(4'hC, v); chk("R9 unmapped read", v, 32'h0);
    wr(4'h4, 32'h00000081);
    rd(4'h4, v); chk("R2 bad key ctl A", v & 32'hFFFF_FFDF, 32'h0);

    // disabled hold
    repeat (20) @(posedge clk);
    rd(4'h0, v); chk("R10 hold while disabled", v, 32'h1234);

    // tick gating
    wr(4'h4, 32'hA5A5A500);
    wr(4'h0, 32'h5A5A0010);
    @(negedge clk) tick = 1'b0;
    wr(4'h4, 32'hA5A5A580);
    repeat (30) @(posedge clk);
    rd(4'h0, v); chk("R4 no count without tick", v, 32'h0010);
    tick = 1'b1;
    repeat (5) @(posedge clk);
    rd(4'h0, v); chk("R4 count with tick", v, 32'h0015);
    wr(4'h4, 32'hA5A5A500);

    // prescaler sweep
    for (int s = 0; s < 8; s++) begin
      wr(4'h4, 32'hA5A5A500 | s);
      wr(4'h0, 32'h5A5AFFFC);
      repeat (3) @(posedge clk);
      wr(4'h4, 32'hA5A5A580 | s);
      wait_ovf(n);
      chk($sformatf("R4 ticks to overflow sel %0d", s), n, 4 * ratio(s));
      pulse_len(h);
      chk($sformatf("R6 pulse width sel %0d", s), h, 16);
      rd(4'h4, v); chk($sformatf("R6 status after overflow sel %0d", s), v, 32'h10 | s);
      repeat (10) @(posedge clk);
      rd(4'h0, v); chk($sformatf("R6 counter parked sel %0d", s), v, 32'h0);
      chk($sformatf("R6 no second pulse sel %0d", s), {31'b0, wrst}, 32'h0);
      if (s == 0) begin
        wr(4'h4, 32'hA5A5A510);
        rd(4'h4, v); chk("R7 write 1 keeps ovf", v & 32'h10, 32'h10);
        wr(4'h4, 32'h00000000);
        rd(4'h4, v); chk("R7 bad key keeps ovf", v & 32'h10, 32'h10);
      end
      wr(4'h4, 32'hA5A5A500 | s);
      rd(4'h4, v); chk($sformatf("R7 ovf cleared sel %0d", s), v & 32'h10, 32'h0);
    end

    // immediate forced reset
    wr(4'h0, 32'h5A5A0100);
    wr(4'h4, 32'hA5A5A580);
    repeat (4) @(posedge clk);
    wr(4'h0, 32'h5A5AFFFF);
    wait_ovf(n);
    chk("R5 forced overflow latency", n, 1);
    pulse_len(h);
    chk("R5 forced pulse width", h, 16);
    rd(4'h4, v); chk("R5 status after forced", v, 32'h10);
    rd(4'h8, v); chk("R9 ctl B unaffected", v, 32'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule